// File: doc/BRIEF.md
# Configurable Interrupt Source Latch

A bank of interrupt source slices that sits between raw interrupt lines and a downstream priority and delivery stage. Every clock edge each slice samples its raw line, keeps a cached copy of the level it saw, and updates a pending flag according to its configured sensitivity. In level-sensitive mode pending simply follows the line. In edge-sensitive mode pending is set whenever the line is seen high and stays set until acknowledged. A requester that raises its line and holds it still counts as an event, so no rising-edge check is made.

Software writes one 32-bit configuration word per source through a simple write port. The word holds a mask, a sense selector and a no-mask attribute for critical sources. A source may latch an edge while masked and before software has set its real sense. If software then switches it to level-sensitive mode, pending is reloaded from the cached line level. A stale latch whose line has since dropped is therefore discarded and cannot flood the delivery stage. An acknowledge strobe names one source and retires an edge-sensitive event. Each slice drives a registered request line and an activity flag.

Top module: `irq_src_bank`

## Requirements
- R1: `lvl_o[i]` equals the value of `irq_in[i]` at the previous rising clock edge, whatever sense source i is configured for.
- R2: For a level-sensitive source, `pend_o[i]` after each edge equals `irq_in[i]` sampled at that edge.
- R3: For an edge-sensitive source, `pend_o[i]` is set after any edge at which `irq_in[i]` is high. It is not cleared when the line falls.
- R4: A write with `cfg_we`=1 loads the word `cfg_wdata` into source `cfg_idx`. Bit 22 is the sense (1 = level, 0 = edge), bit 31 is the mask (1 = masked) and bit 21 is no-mask (1 = ignore the mask). All other bits are ignored, and an index at or beyond the source count writes nothing.
- R5: A write that leaves a source level-sensitive reloads its pending flag at that same edge from the line level, which drops a stale edge latch.
- R6: When a line changes at the same edge as a configuration write to that source, the new line value is used both for the cached level and for the level-mode reload.
- R7: An acknowledge (`ack_vld`=1, `ack_idx`=i) to a source that is edge-sensitive before that edge clears both `pend_o[i]` and `act_o[i]`. If the line is still high at that edge, the source is pending again.
- R8: An acknowledge to a level-sensitive source changes nothing, and pending stays equal to the line level.
- R9: `req_o[i]` is registered and equals `pend_o[i] & (~mask | nomask)`. It changes in the cycle after the line, configuration or acknowledge that caused the change.
- R10: A source with no-mask set raises its request while pending even when its mask bit is 1.
- R11: `act_o[i]` is 1 whenever `req_o[i]` is 1. An edge-sensitive source keeps it until acknowledged, and a level-sensitive source clears it when the request drops.
- R12: After reset every source is masked and edge-sensitive with no-mask clear, and pending, cached level, request and activity are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index for the write |
| cfg_wdata | input | 32 | Configuration word |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Source index being acknowledged |
| req_o | output | NUM_SRC | Request to the delivery stage |
| pend_o | output | NUM_SRC | Pending flags |
| act_o | output | NUM_SRC | Activity flags |
| lvl_o | output | NUM_SRC | Cached raw line levels |

## Verification
The properties assume that the raw lines are already synchronous to `clk` and that at most one write and one acknowledge arrive per cycle. The bench meets this by changing lines and strobes only at the falling edge. The past-value checks also assume that one full clock has passed since reset was released, and the checker waits for that before judging anything. The stimulus drives acknowledges into both modes and sends writes that switch a source to level sensitivity while the line is both high and low. It also changes a line at the very edge of a write, so the reload and the acknowledge rules are exercised on the states where they differ.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

   localparam int CFG_W      = 32;
   localparam int MASK_POS   = 31;
   localparam int SENSE_POS  = 22;
   localparam int NOMASK_POS = 21;

   typedef struct packed {
      logic mask;    // 1: request blocked unless nomask
      logic sense;   // 1: level-sensitive, 0: edge-sensitive
      logic nomask;  // 1: critical source, mask ignored
   } src_cfg_t;

   localparam src_cfg_t CFG_RESET = '{mask: 1'b1, sense: 1'b0, nomask: 1'b0};

   function automatic src_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
      src_cfg_t c;
      c.mask   = w[MASK_POS];
      c.sense  = w[SENSE_POS];
      c.nomask = w[NOMASK_POS];
      return c;
   endfunction

endpackage

// File: rtl/irq_src_onehot.sv
module irq_src_onehot #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic               vld,
   input  logic [IDX_W-1:0]   idx,
   output logic [NUM_SRC-1:0] hit
);

   initial begin
      if (NUM_SRC < 1) $error("irq_src_onehot: NUM_SRC must be at least 1");
      if ((1 << IDX_W) < NUM_SRC) $error("irq_src_onehot: IDX_W too narrow");
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
      assign hit[g] = vld && (idx == IDX_W'(g));
   end

endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice
   import irq_src_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     raw,
   input  logic     wr_hit,
   input  src_cfg_t wr_cfg,
   input  logic     ack_hit,
   output src_cfg_t cfg_q,
   output logic     pend_q,
   output logic     req_q,
   output logic     act_q,
   output logic     lvl_q
);

   src_cfg_t cfg_nx;
   logic     pend_nx;
   logic     req_nx;
   logic     act_nx;
   logic     ack_edge;

   // an acknowledge only retires a source that was edge-sensitive before this edge
   assign ack_edge = ack_hit && !cfg_q.sense;

   always_comb begin
      cfg_nx = wr_hit ? wr_cfg : cfg_q;

      // level mode (including a fresh switch to it) follows the new raw value
      if (cfg_nx.sense)      pend_nx = raw;
      else if (raw)          pend_nx = 1'b1;
      else if (ack_edge)     pend_nx = 1'b0;
      else                   pend_nx = pend_q;

      req_nx = pend_nx && (!cfg_nx.mask || cfg_nx.nomask);

      if (req_nx)            act_nx = 1'b1;
      else if (cfg_nx.sense) act_nx = 1'b0;
      else if (ack_edge)     act_nx = 1'b0;
      else                   act_nx = act_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RESET;
         pend_q <= 1'b0;
         req_q  <= 1'b0;
         act_q  <= 1'b0;
         lvl_q  <= 1'b0;
      end else begin
         cfg_q  <= cfg_nx;
         pend_q <= pend_nx;
         req_q  <= req_nx;
         act_q  <= act_nx;
         lvl_q  <= raw;
      end
   end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_src_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               ack_vld,
   input  logic [IDX_W-1:0]   ack_idx,
   output logic [NUM_SRC-1:0] req_o,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] act_o,
   output logic [NUM_SRC-1:0] lvl_o
);

   initial begin
      if (NUM_SRC < 1) $error("irq_src_bank: NUM_SRC must be at least 1");
      if ((1 << IDX_W) < NUM_SRC) $error("irq_src_bank: IDX_W cannot address every source");
      if (MASK_POS == SENSE_POS || MASK_POS == NOMASK_POS || SENSE_POS == NOMASK_POS)
         $error("irq_src_bank: configuration field positions overlap");
   end

   logic [NUM_SRC-1:0] wr_hit;
   logic [NUM_SRC-1:0] ack_hit;
   logic [NUM_SRC-1:0] sense_v;
   logic [NUM_SRC-1:0] mask_v;
   logic [NUM_SRC-1:0] nomask_v;
   src_cfg_t           wr_cfg;

   assign wr_cfg = cfg_from_word(cfg_wdata);

   irq_src_onehot #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_wr_dec (
      .vld (cfg_we),
      .idx (cfg_idx),
      .hit (wr_hit)
   );

   irq_src_onehot #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ack_dec (
      .vld (ack_vld),
      .idx (ack_idx),
      .hit (ack_hit)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      src_cfg_t cfg_s;

      irq_src_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw     (irq_in[g]),
         .wr_hit  (wr_hit[g]),
         .wr_cfg  (wr_cfg),
         .ack_hit (ack_hit[g]),
         .cfg_q   (cfg_s),
         .pend_q  (pend_o[g]),
         .req_q   (req_o[g]),
         .act_q   (act_o[g]),
         .lvl_q   (lvl_o[g])
      );

      assign sense_v[g]  = cfg_s.sense;
      assign mask_v[g]   = cfg_s.mask;
      assign nomask_v[g] = cfg_s.nomask;
   end

endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_in,
   input logic               ack_vld,
   input logic [IDX_W-1:0]   ack_idx,
   input logic [NUM_SRC-1:0] req_o,
   input logic [NUM_SRC-1:0] pend_o,
   input logic [NUM_SRC-1:0] act_o,
   input logic [NUM_SRC-1:0] lvl_o,
   input logic [NUM_SRC-1:0] sense_v,
   input logic [NUM_SRC-1:0] mask_v,
   input logic [NUM_SRC-1:0] nomask_v
);

   logic               seen;
   logic [NUM_SRC-1:0] ackv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   always_comb begin
      ackv = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (ack_vld && ack_idx == IDX_W'(i)) ackv[i] = 1'b1;
   end

   assert_lvl_cache_R1: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (lvl_o == $past(irq_in)));

   // R2 and R5: a level-sensitive source never disagrees with its cached line
   assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense_v & (pend_o ^ lvl_o)) == '0));

   assert_edge_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> ((~sense_v & $past(irq_in) & ~pend_o) == '0));

   assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> ((~sense_v & $past(pend_o & ~ackv) & ~pend_o) == '0));

   assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> ((~sense_v & $past(ackv & ~sense_v & ~irq_in) & (pend_o | act_o)) == '0));

   assert_req_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o == (pend_o & (~mask_v | nomask_v))));

   assert_act_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_o & ~act_o) == '0));

endmodule

bind irq_src_bank irq_src_bank_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_in   (irq_in),
   .ack_vld  (ack_vld),
   .ack_idx  (ack_idx),
   .req_o    (req_o),
   .pend_o   (pend_o),
   .act_o    (act_o),
   .lvl_o    (lvl_o),
   .sense_v  (sense_v),
   .mask_v   (mask_v),
   .nomask_v (nomask_v)
);

// File: tb/irq_src_bank_tb.sv
module irq_src_bank_tb;

   localparam int N  = 4;
   localparam int IW = 2;

   localparam logic [31:0] W_EDGE_UNM = 32'h0000_0000;
   localparam logic [31:0] W_EDGE_MSK = 32'h8000_0000;
   localparam logic [31:0] W_LVL_UNM  = 32'h0040_0000;
   localparam logic [31:0] W_LVL_MSK  = 32'h8040_0000;
   localparam logic [31:0] W_EDGE_NM  = 32'h8020_0000;

   typedef struct packed {
      logic [3:0]  irq;
      logic        we;
      logic [1:0]  widx;
      logic [31:0] wd;
      logic        ak;
      logic [1:0]  aidx;
      logic [3:0]  ep;
      logic [3:0]  er;
      logic [3:0]  ea;
      logic [3:0]  el;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{4'b0001, 1'b0, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0001, 4'b0000, 4'b0000, 4'b0001}, // R3 R1 masked edge latches
      '{4'b0000, 1'b0, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0001, 4'b0000, 4'b0000, 4'b0000}, // R3 fall keeps pending
      '{4'b0000, 1'b1, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0001, 4'b0001, 4'b0001, 4'b0000}, // R4 R9 unmask
      '{4'b0000, 1'b0, 2'd0, W_EDGE_UNM, 1'b1, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R7 ack edge
      '{4'b0010, 1'b0, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0010, 4'b0000, 4'b0000, 4'b0010}, // R3 src1 latch
      '{4'b0000, 1'b0, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0010, 4'b0000, 4'b0000, 4'b0000}, // R3 stale latch
      '{4'b0000, 1'b1, 2'd1, W_LVL_MSK,  1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R5 reload drops it
      '{4'b0010, 1'b0, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0010, 4'b0000, 4'b0000, 4'b0010}, // R2 level follows
      '{4'b0010, 1'b1, 2'd1, W_LVL_UNM,  1'b0, 2'd0, 4'b0010, 4'b0010, 4'b0010, 4'b0010}, // R9 R11 unmask level
      '{4'b0010, 1'b0, 2'd0, W_EDGE_UNM, 1'b1, 2'd1, 4'b0010, 4'b0010, 4'b0010, 4'b0010}, // R8 ack level no effect
      '{4'b0000, 1'b0, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R2 R11 level drop
      '{4'b0001, 1'b1, 2'd0, W_EDGE_NM,  1'b0, 2'd0, 4'b0001, 4'b0001, 4'b0001, 4'b0001}, // R10 nomask
      '{4'b0001, 1'b0, 2'd0, W_EDGE_UNM, 1'b0, 2'd0, 4'b0001, 4'b0001, 4'b0001, 4'b0001}, // R10 hold
      '{4'b0000, 1'b1, 2'd0, W_LVL_UNM,  1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000}  // R6 same-edge low line
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          ack_vld = 1'b0;
   logic [IW-1:0] ack_idx = '0;
   logic [N-1:0]  req_o, pend_o, act_o, lvl_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_src_bank #(.NUM_SRC(N), .IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .ack_vld(ack_vld), .ack_idx(ack_idx),
      .req_o(req_o), .pend_o(pend_o), .act_o(act_o), .lvl_o(lvl_o)
   );

   task automatic chk(input string tag, input string what, input logic [N-1:0] got, input logic [N-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, got, exp);
      end
   endtask

   // drive at falling edge, one rising edge, sample at the next falling edge
   task automatic step(input logic [N-1:0] irq, input logic we, input logic [IW-1:0] wi,
                       input logic [31:0] wd, input logic ak, input logic [IW-1:0] ai);
      irq_in = irq; cfg_we = we; cfg_idx = wi; cfg_wdata = wd; ack_vld = ak; ack_idx = ai;
      @(negedge clk);
      cfg_we = 1'b0; ack_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R12", "pend", pend_o, '0);
      chk("R12", "req",  req_o,  '0);
      chk("R12", "act",  act_o,  '0);
      chk("R12", "lvl",  lvl_o,  '0);

      for (int k = 0; k < NV; k++) begin
         step(VEC[k].irq, VEC[k].we, VEC[k].widx, VEC[k].wd, VEC[k].ak, VEC[k].aidx);
         chk($sformatf("row%0d", k), "pend", pend_o, VEC[k].ep);
         chk($sformatf("row%0d", k), "req",  req_o,  VEC[k].er);
         chk($sformatf("row%0d", k), "act",  act_o,  VEC[k].ea);
         chk($sformatf("row%0d", k), "lvl",  lvl_o,  VEC[k].el);
      end

      // R7: acknowledge while the edge line is still high re-latches
      step(4'b0100, 1'b1, 2'd2, W_EDGE_UNM, 1'b0, 2'd0);
      chk("R7", "pend src2 set", pend_o, 4'b0100);
      step(4'b0100, 1'b0, 2'd0, '0, 1'b1, 2'd2);
      chk("R7", "pend relatch", pend_o, 4'b0100);
      chk("R7", "act relatch",  act_o,  4'b0100);
      step(4'b0000, 1'b0, 2'd0, '0, 1'b1, 2'd2);
      chk("R7", "pend cleared", pend_o, 4'b0000);
      chk("R7", "act cleared",  act_o,  4'b0000);

      // R9: masking drops the request next cycle but keeps the latch
      step(4'b1000, 1'b1, 2'd3, W_EDGE_UNM, 1'b0, 2'd0);
      chk("R9", "req src3", req_o, 4'b1000);
      step(4'b0000, 1'b1, 2'd3, W_EDGE_MSK, 1'b0, 2'd0);
      chk("R9", "req masked", req_o,  4'b0000);
      chk("R9", "pend kept",  pend_o, 4'b1000);

      // R4: bits outside the three fields are ignored (sense bit clear stays edge)
      step(4'b0000, 1'b1, 2'd3, 32'h7F9F_FFFF, 1'b0, 2'd0);
      chk("R4", "pend kept edge", pend_o, 4'b1000);
      chk("R4", "req unmasked",   req_o,  4'b1000);

      // R12: a second reset returns everything to idle
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12", "pend after reset", pend_o, '0);
      chk("R12", "req after reset",  req_o,  '0);
      rst_n = 1'b1;
      step(4'b0001, 1'b0, 2'd0, '0, 1'b0, 2'd0);
      chk("R12", "masked after reset", req_o, '0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule